// File: doc/BRIEF.md
# Two-Wire Bus Target Controller with Clock Stretching

This block answers as a target (slave) on a two-wire I2C bus. The open-drain clock and data lines are read through a short synchronizer chain. The block drives each line only by pulling it low, through one enable per line. It finds START and STOP conditions on the bus and compares the address header with its own address, in either the 7-bit or the 10-bit form. It then receives or sends bytes, with an acknowledge slot after every byte.

The local side is a plain byte interface. A received data byte appears on `rx_data` with a one-cycle `rx_valid` strobe. For a read, the block raises `tx_req` and holds the clock line low until a byte arrives on `tx_data` with `tx_valid`.

In the write direction, stretching is under local control. While `clk_release` is low, the clock stays held after every acknowledged data byte. Raising `clk_release` lets the bus clock run again.

Top module: `i2c_target_ctl`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts address reception from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) releases both lines and returns the block to idle. After reset neither line is pulled and no strobe is active.
- R2: With `addr10_en`=0, the first byte after START is seven address bits, MSB first, followed by a direction bit (0 = write, 1 = read). The block pulls SDA low in the 9th clock only when those seven bits equal `own_addr[6:0]`.
- R3: With `addr10_en`=1, the first byte must be 1,1,1,1,0 followed by `own_addr[9:8]` and then the direction bit. The second byte must equal `own_addr[7:0]`. Each byte is acknowledged only if it matches, and any other first byte is not acknowledged.
- R4: With `addr10_en`=1, a repeated START carrying the 10-bit header with direction bit 1 selects read mode, provided a full 10-bit write addressing has completed since the last STOP. After a STOP, the same header is not acknowledged.
- R5: In write mode, every data byte is acknowledged. It is presented MSB first on `rx_data` together with a one-cycle `rx_valid` pulse after its 8th bit is sampled.
- R6: After an address that is not acknowledged, SDA stays released in the 9th clock. Later bytes up to the next START are neither acknowledged nor reported.
- R7: When a read is addressed, and again after each byte the master acknowledges, `tx_req` pulses once. SCL is then held low until `tx_valid` supplies a byte, which is shifted out MSB first.
- R8: A not-acknowledge from the master after a transmitted byte releases SDA and SCL, with no further `tx_req`.
- R9: In write mode with `clk_release`=0, SCL is held low after each acknowledged data byte and the transfer is frozen until `clk_release` becomes 1. With `clk_release`=1, no stretching happens.
- R10: The block starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| own_addr | input | 10 | Own address (bits 6:0 used in 7-bit mode) |
| addr10_en | input | 1 | 1 selects 10-bit addressing |
| clk_release | input | 1 | 0 permits clock stretching after received data bytes |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for a new received byte |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Strobe that supplies `tx_data` |
| tx_req | output | 1 | One-cycle request for the next transmit byte |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except to form START or STOP. It keeps each line level for several system clocks, well beyond the synchronizer delay. It waits for SCL to actually read high before counting a clock as started, so it honours stretching. The bench master model keeps to these rules: it waits ten cycles after each line change and polls the SCL line level before timing its high phase. Every 7-bit address, a set of 10-bit headers and low bytes, mid-byte restarts and stretch windows are all driven under that discipline.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 10;
    localparam int CNT_W   = 4;
    localparam logic [4:0] HDR10_TAG = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_RX_HOLD,
        ST_TX_WAIT,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;

    typedef enum logic [1:0] {
        K_ADDR_HI,
        K_ADDR_LO,
        K_DATA
    } byte_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic ack;
        logic to_read;
        logic to_lo;
        logic hdr_done;
    } addr_dec_t;

    function automatic logic hdr10_match(logic [BYTE_W-1:0] b, logic [1:0] hi);
        return (b[7:3] == HDR10_TAG) && (b[2:1] == hi);
    endfunction

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[LAST];
            sda_q    <= sda_pipe[LAST];
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[LAST];
        ev.sda      = sda_pipe[LAST];
        ev.scl_rise = scl_pipe[LAST] & ~scl_q;
        ev.scl_fall = ~scl_pipe[LAST] & scl_q;
        ev.start    = scl_pipe[LAST] & scl_q & sda_q & ~sda_pipe[LAST];
        ev.stop     = scl_pipe[LAST] & scl_q & ~sda_q & sda_pipe[LAST];
    end

endmodule

// File: rtl/i2c_addr_dec.sv
module i2c_addr_dec
    import i2c_tgt_pkg::*;
(
    input  byte_kind_e        kind,
    input  logic [BYTE_W-1:0] rx_b,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              addr10_en,
    input  logic              hdr_wr_ok,
    output addr_dec_t         dec
);
    always_comb begin
        dec = '0;
        case (kind)
            K_ADDR_HI: begin
                if (!addr10_en) begin
                    dec.ack     = (rx_b[7:1] == own_addr[6:0]);
                    dec.to_read = rx_b[0];
                end else if (hdr10_match(rx_b, own_addr[9:8])) begin
                    if (!rx_b[0]) begin
                        dec.ack   = 1'b1;
                        dec.to_lo = 1'b1;
                    end else if (hdr_wr_ok) begin
                        dec.ack     = 1'b1;
                        dec.to_read = 1'b1;
                    end
                end
            end
            K_ADDR_LO: begin
                dec.ack      = (rx_b == own_addr[7:0]);
                dec.hdr_done = (rx_b == own_addr[7:0]);
            end
            default: dec.ack = 1'b1;
        endcase
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  addr_dec_t         dec,
    input  logic              clk_release,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output byte_kind_e        kind,
    output logic [BYTE_W-1:0] cur_byte,
    output logic              hdr_wr_ok,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_req
);
    tgt_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_now;
    logic              in_slot;
    logic              going_read;
    logic              going_lo;
    logic              mack;

    assign cur_byte = {shreg[BYTE_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            kind       <= K_ADDR_HI;
            cnt        <= '0;
            shreg      <= '0;
            ack_now    <= 1'b0;
            in_slot    <= 1'b0;
            going_read <= 1'b0;
            going_lo   <= 1'b0;
            mack       <= 1'b0;
            hdr_wr_ok  <= 1'b0;
            scl_pull   <= 1'b0;
            sda_pull   <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            tx_req     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            if (ev.start) begin
                st       <= ST_RX;
                kind     <= K_ADDR_HI;
                cnt      <= '0;
                in_slot  <= 1'b0;
                scl_pull <= 1'b0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                st        <= ST_IDLE;
                in_slot   <= 1'b0;
                hdr_wr_ok <= 1'b0;
                scl_pull  <= 1'b0;
                sda_pull  <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            shreg <= cur_byte;
                            cnt   <= cnt + 4'd1;
                            if (cnt == 4'd7) begin
                                st         <= ST_RX_ACK;
                                in_slot    <= 1'b0;
                                ack_now    <= dec.ack;
                                going_read <= dec.to_read;
                                going_lo   <= dec.to_lo;
                                if (dec.to_lo)    hdr_wr_ok <= 1'b0;
                                if (dec.hdr_done) hdr_wr_ok <= 1'b1;
                                if (kind == K_DATA) begin
                                    rx_data  <= cur_byte;
                                    rx_valid <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            if (!in_slot) begin
                                in_slot  <= 1'b1;
                                sda_pull <= ack_now;
                            end else begin
                                in_slot  <= 1'b0;
                                sda_pull <= 1'b0;
                                cnt      <= '0;
                                if (!ack_now) begin
                                    st <= ST_IDLE;
                                end else if (going_read) begin
                                    st       <= ST_TX_WAIT;
                                    scl_pull <= 1'b1;
                                    tx_req   <= 1'b1;
                                end else begin
                                    kind <= going_lo ? K_ADDR_LO : K_DATA;
                                    if (kind == K_DATA && !clk_release) begin
                                        st       <= ST_RX_HOLD;
                                        scl_pull <= 1'b1;
                                    end else begin
                                        st <= ST_RX;
                                    end
                                end
                            end
                        end
                    end
                    ST_RX_HOLD: begin
                        if (clk_release) begin
                            scl_pull <= 1'b0;
                            st       <= ST_RX;
                        end
                    end
                    ST_TX_WAIT: begin
                        if (tx_valid) begin
                            shreg    <= {tx_data[BYTE_W-2:0], 1'b0};
                            sda_pull <= ~tx_data[BYTE_W-1];
                            scl_pull <= 1'b0;
                            cnt      <= '0;
                            st       <= ST_TX;
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) cnt <= cnt + 4'd1;
                        if (ev.scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_pull <= 1'b0;
                                st       <= ST_TX_ACK;
                            end else begin
                                sda_pull <= ~shreg[BYTE_W-1];
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) mack <= ~ev.sda;
                        if (ev.scl_fall) begin
                            if (mack) begin
                                st       <= ST_TX_WAIT;
                                scl_pull <= 1'b1;
                                tx_req   <= 1'b1;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10
    sda_pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !$past(ev.scl));

    // R7
    tx_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TX_WAIT && !tx_valid && !ev.start && !ev.stop) |=> scl_pull);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RX_HOLD && !clk_release && !ev.start && !ev.stop) |=> scl_pull);

    // R5
    rx_valid_edge_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(ev.scl_rise));

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!scl_pull && !sda_pull));

    // R8
    nack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TX_ACK && ev.scl_fall && !mack && !ev.start && !ev.stop)
        |=> (!scl_pull && !sda_pull && !tx_req));

endmodule

// File: rtl/i2c_target_ctl.sv
module i2c_target_ctl
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              addr10_en,
    input  logic              clk_release,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_req
);
    bus_ev_t           ev;
    addr_dec_t         dec;
    byte_kind_e        kind;
    logic [BYTE_W-1:0] cur_byte;
    logic              hdr_wr_ok;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_addr_dec u_dec (
        .kind      (kind),
        .rx_b      (cur_byte),
        .own_addr  (own_addr),
        .addr10_en (addr10_en),
        .hdr_wr_ok (hdr_wr_ok),
        .dec       (dec)
    );

    i2c_tgt_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .dec         (dec),
        .clk_release (clk_release),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .kind        (kind),
        .cur_byte    (cur_byte),
        .hdr_wr_ok   (hdr_wr_ok),
        .scl_pull    (scl_pull),
        .sda_pull    (sda_pull),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .tx_req      (tx_req)
    );

endmodule

// File: tb/i2c_target_ctl_tb.sv
module i2c_target_ctl_tb;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_line, sda_line;
    logic       scl_pull, sda_pull;
    logic [9:0] own_addr = 10'h05A;
    logic       addr10_en = 1'b0;
    logic       clk_release = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_req;

    int         checks = 0;
    int         fails = 0;
    int         rx_cnt = 0;
    int         txreq_cnt = 0;
    int         sda_viol = 0;
    logic [7:0] last_rx = 8'h00;
    logic       prev_sda_pull = 1'b0;

    always #2 clk = ~clk;

    assign scl_line = !(m_scl_low || scl_pull);
    assign sda_line = !(m_sda_low || sda_pull);

    i2c_target_ctl u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .own_addr(own_addr),
        .addr10_en(addr10_en), .clk_release(clk_release), .rx_data(rx_data),
        .rx_valid(rx_valid), .tx_data(tx_data), .tx_valid(tx_valid), .tx_req(tx_req)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                rx_cnt  <= rx_cnt + 1;
                last_rx <= rx_data;
            end
            if (tx_req) txreq_cnt <= txreq_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && sda_pull && !prev_sda_pull && scl_line) sda_viol <= sda_viol + 1;
        prev_sda_pull <= sda_pull;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0; wq(Q);
        scl_up(); wq(Q);
        m_sda_low = 1'b1; wq(Q);
        m_scl_low = 1'b1; wq(Q);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1; wq(Q);
        scl_up(); wq(Q);
        m_sda_low = 1'b0; wq(Q);
    endtask

    task automatic m_bit_w(input logic b);
        m_sda_low = !b; wq(Q);
        scl_up(); wq(Q);
        m_scl_low = 1'b1; wq(Q);
    endtask

    task automatic m_bit_r(output logic b);
        m_sda_low = 1'b0; wq(Q);
        scl_up(); wq(Q / 2);
        b = sda_line; wq(Q / 2);
        m_scl_low = 1'b1; wq(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
        m_bit_r(a);
        ack = !a;
    endtask

    task automatic m_rbyte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_bit_r(b);
            d[i] = b;
        end
        m_bit_w(!ack);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic       ack;
        logic [7:0] got;
        int         base;

        wq(6);
        rst = 1'b0;
        wq(4);
        // R1 reset state
        chk("R1 reset scl_pull", scl_pull, 0);
        chk("R1 reset sda_pull", sda_pull, 0);
        chk("R1 reset rx_valid", rx_valid, 0);
        chk("R1 reset tx_req", tx_req, 0);

        // R2 sweep of every 7-bit address in write direction
        for (int a = 0; a < 128; a++) begin
            m_start();
            m_wbyte({7'(a), 1'b0}, ack);
            chk("R2 addr7 ack", ack, (a == 'h5A) ? 1 : 0);
            m_stop();
        end

        // R5 data reception, no stretching with clk_release=1 (R9)
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        chk("R5 addr ack", ack, 1);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d;
            d = 8'((i * 37 + 5) & 255);
            base = rx_cnt;
            m_wbyte(d, ack);
            chk("R5 data ack", ack, 1);
            chk("R5 rx count", rx_cnt, base + 1);
            chk("R5 rx data", last_rx, d);
            if (i == 0) begin
                wq(20);
                chk("R9 no stretch when released", scl_pull, 0);
            end
        end
        m_stop();
        wq(4);
        // R1 stop releases
        chk("R1 stop scl_pull", scl_pull, 0);
        chk("R1 stop sda_pull", sda_pull, 0);

        // R6 ignored after nack
        m_start();
        m_wbyte({7'h5B, 1'b0}, ack);
        chk("R6 wrong addr nack", ack, 0);
        base = rx_cnt;
        m_wbyte(8'hA5, ack);
        chk("R6 data after nack not acked", ack, 0);
        chk("R6 data after nack not reported", rx_cnt, base);
        m_stop();

        // R9 receive stretching
        clk_release = 1'b0;
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        chk("R9 addr ack", ack, 1);
        wq(20);
        chk("R9 no hold after address", scl_pull, 0);
        m_wbyte(8'h96, ack);
        chk("R9 byte1 ack", ack, 1);
        wq(20);
        chk("R9 hold after data", scl_pull, 1);
        base = rx_cnt;
        fork
            m_wbyte(8'h3C, ack);
            begin
                wq(60);
                chk("R9 clock frozen", scl_line, 0);
                chk("R9 no progress while frozen", rx_cnt, base);
                clk_release = 1'b1;
            end
        join
        chk("R9 byte2 ack", ack, 1);
        chk("R9 byte2 data", last_rx, 8'h3C);
        m_stop();

        // R7 / R8 transmit in 7-bit mode
        m_start();
        base = txreq_cnt;
        m_wbyte({7'h5A, 1'b1}, ack);
        chk("R7 read addr ack", ack, 1);
        wq(20);
        chk("R7 tx_req after read addr", txreq_cnt, base + 1);
        chk("R7 hold waiting data", scl_pull, 1);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d;
            d = 8'((i * 53 + 17) & 255);
            tx_data = d;
            tx_valid = 1'b1;
            wq(1);
            tx_valid = 1'b0;
            base = txreq_cnt;
            m_rbyte(got, i < 5);
            chk("R7 tx byte", got, d);
            wq(20);
            if (i < 5) begin
                chk("R7 tx_req after master ack", txreq_cnt, base + 1);
                chk("R7 hold after master ack", scl_pull, 1);
            end else begin
                chk("R8 no tx_req after nack", txreq_cnt, base);
                chk("R8 scl released after nack", scl_pull, 0);
                chk("R8 sda released after nack", sda_pull, 0);
            end
        end
        m_stop();

        // R1 restart in the middle of a byte
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        for (int i = 0; i < 4; i++) m_bit_w(1'b0);
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        chk("R1 restart addr ack", ack, 1);
        m_wbyte(8'hC7, ack);
        chk("R1 restart data", last_rx, 8'hC7);
        m_stop();

        // R3 10-bit addressing, own address 0x2D3 (A9A8 = 2'b10)
        addr10_en = 1'b1;
        own_addr = 10'h2D3;
        for (int h = 0; h < 4; h++) begin
            m_start();
            m_wbyte({5'b11110, 2'(h), 1'b0}, ack);
            chk("R3 header ack", ack, (h == 2) ? 1 : 0);
            if (ack) begin
                m_wbyte(8'hD3, ack);
                chk("R3 low byte ack", ack, 1);
            end
            m_stop();
        end
        for (int k = 0; k < 16; k++) begin
            logic [7:0] lo;
            lo = 8'(k * 16 + 3);
            m_start();
            m_wbyte(8'hF4, ack);
            chk("R3 header ack", ack, 1);
            m_wbyte(lo, ack);
            chk("R3 low byte match", ack, (lo == 8'hD3) ? 1 : 0);
            if (ack) begin
                m_wbyte(8'h5E, ack);
                chk("R3 data after 10-bit", last_rx, 8'h5E);
            end
            m_stop();
        end
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        chk("R3 7-bit byte in 10-bit mode", ack, 0);
        m_stop();

        // R4 10-bit read via repeated start
        m_start();
        m_wbyte(8'hF4, ack);
        m_wbyte(8'hD3, ack);
        chk("R4 write addressing", ack, 1);
        base = txreq_cnt;
        m_start();
        m_wbyte(8'hF5, ack);
        chk("R4 read header ack", ack, 1);
        wq(20);
        chk("R4 tx_req", txreq_cnt, base + 1);
        tx_data = 8'h81;
        tx_valid = 1'b1;
        wq(1);
        tx_valid = 1'b0;
        m_rbyte(got, 1'b0);
        chk("R4 read data", got, 8'h81);
        m_stop();
        m_start();
        m_wbyte(8'hF5, ack);
        chk("R4 read header after stop", ack, 0);
        m_stop();

        // R10 data line changed only while clock low
        chk("R10 sda pull raised with scl high", sda_viol, 0);

        finish_run();
    end

endmodule